// File: doc/BRIEF.md
# Misaligned Access Bus Splitter

This block sits between a load/store requester and a 32-bit memory or I/O bus. The requester hands over one access at a time: a byte, a halfword or a full 32-bit operand at any byte address. The block turns it into the bus cycles that the bus can carry. Every bus cycle names a 32-bit aligned word and drives four active-low byte enables. Store data is moved onto the byte lanes that match the address. Load data is picked off the lanes and packed back into an operand whose least significant byte comes from the lowest address.

An operand that runs past a 4-byte boundary needs two aligned words. The block issues the lower word first and the higher word second. The bus slave stretches any cycle by holding back its ready input. A slave that is only 16 bits wide says so with a half-width input. The block then moves the upper pair of lanes in an extra cycle, shifted down onto the lower pair. The requester sees a busy flag while an access runs, and a one-clock done pulse when it has finished.

Top module: `spl_misalign_bus`

## Requirements
- R1: While reset is held and after it is released, with no request given, bus_active, bus_strobe, req_busy and req_done are low and bus_be_n is 4'b1111.
- R2: req_size selects the operand length: 2'b00 is one byte, 2'b01 is two bytes, 2'b10 and 2'b11 are four bytes. In each bus cycle, bus_be_n[i] is low exactly for the operand bytes whose address has bits [1:0] equal to i and that fall in the word given by bus_word. For the first cycle, bus_word is req_addr[ADDR_W-1:2].
- R3: An operand whose bytes span two aligned words takes two bus cycles. The lower word goes first. The second cycle drives bus_word plus one, wrapping modulo 2^(ADDR_W-2). An operand inside one word takes exactly one cycle.
- R4: On a store, operand byte k, counted from the least significant, is driven on lane (req_addr[1:0]+k) mod 4 of the cycle whose word holds address req_addr+k.
- R5: On a load, byte k of req_rdata is the byte read from address req_addr+k. Bytes at and above the operand length read as zero.
- R6: bus_strobe is high for exactly the first clock of each bus cycle. bus_word, bus_be_n, bus_write and bus_mem hold steady for the whole cycle. bus_write equals req_write. bus_mem is high for a memory access (req_io low) and low for an I/O access.
- R7: A bus cycle ends at the first rising edge after its strobe clock at which bus_ready is high. bus_ready during the strobe clock, or while no cycle runs, has no effect.
- R8: If bus_half is high when a cycle ends and that cycle enabled lanes from both halves, only lanes 0 and 1 count as moved. A further cycle follows at the same bus_word, with only the lane 2 and 3 enables low.
- R9: In a cycle that enables only lanes 2 and 3, store data for those lanes is also driven on lanes 0 and 1. If bus_half is high when such a cycle ends, load bytes for lanes 2 and 3 are taken from lanes 0 and 1.
- R10: A request is taken only when req_busy is low. req_busy is high from the clock after acceptance until the access completes. req_valid has no effect while req_busy is high.
- R11: req_done is high for one clock, starting the clock after the final bus cycle ends. req_rdata is valid then and holds until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_size | input | 2 | Operand length code |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_wdata | input | BUS_W | Store operand, least significant byte first |
| req_busy | output | 1 | Access in progress |
| req_done | output | 1 | One-clock completion pulse |
| req_rdata | output | BUS_W | Assembled load operand |
| bus_strobe | output | 1 | First clock of a bus cycle |
| bus_active | output | 1 | Bus cycle in progress |
| bus_word | output | ADDR_W-2 | Aligned word address (byte address bits ADDR_W-1..2) |
| bus_be_n | output | BUS_W/8 | Byte enables, active low |
| bus_write | output | 1 | 1 = write cycle |
| bus_mem | output | 1 | 1 = memory cycle, 0 = I/O cycle |
| bus_wdata | output | BUS_W | Store data on byte lanes |
| bus_rdata | input | BUS_W | Load data from byte lanes |
| bus_ready | input | 1 | Ends the current cycle |
| bus_half | input | 1 | Slave is 16 bits wide, sampled with bus_ready |

## Verification
The bench builds the block with ADDR_W = 10, so the bus word field is eight bits wide. Operands that start at byte 1022 or 1023 then need a second word that wraps to word 0, and the bench sends such operands on purpose. The bus is 32 bits and the half-width option is enabled. This lets the bench drive bus_half for each request and reach both the extra upper-half cycle and the case where only the upper lanes are enabled. A random delay of zero to three wait clocks is drawn for each cycle.

// File: rtl/spl_pkg.sv
package spl_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_XFER = 2'd1,
      SEQ_DONE = 2'd2
   } seq_state_e;

   // Lane span of an operand over two adjacent 4-lane words.
   function automatic logic [7:0] span_of(input logic [1:0] size, input logic [1:0] off);
      logic [7:0] base;
      case (size)
         2'b00:   base = 8'h01;
         2'b01:   base = 8'h03;
         default: base = 8'h0F;
      endcase
      return base << off;
   endfunction

endpackage

// File: rtl/spl_lane_plan.sv
module spl_lane_plan
   import spl_pkg::*;
#(
   parameter int BUS_W = 32
) (
   input  logic [1:0]         off,
   input  logic [1:0]         size,
   input  logic [BUS_W-1:0]   wdata,
   output logic [BUS_W/4-1:0] span,
   output logic [2*BUS_W-1:0] wide
);
   localparam int WIDE_W = 2 * BUS_W;

   logic [WIDE_W-1:0] padded;

   assign span   = span_of(size, off);
   assign padded = {{BUS_W{1'b0}}, wdata};
   assign wide   = padded << {off, 3'b000};

endmodule

// File: rtl/spl_write_steer.sv
module spl_write_steer #(
   parameter int BUS_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [2*BUS_W-1:0] wide_in,
   input  logic               part,
   input  logic               mirror,
   output logic [BUS_W-1:0]   bus_wdata
);
   localparam int HALF_W = BUS_W / 2;

   logic [2*BUS_W-1:0] wide_q;
   logic [BUS_W-1:0]   word_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wide_q <= '0;
      end else if (load) begin
         wide_q <= wide_in;
      end
   end

   assign word_sel  = part ? wide_q[2*BUS_W-1:BUS_W] : wide_q[BUS_W-1:0];
   assign bus_wdata = mirror ? {word_sel[BUS_W-1:HALF_W], word_sel[BUS_W-1:HALF_W]}
                             : word_sel;

endmodule

// File: rtl/spl_cycle_seq.sv
module spl_cycle_seq
   import spl_pkg::*;
#(
   parameter int WORD_W = 30,
   parameter int NL     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] start_word,
   input  logic [2*NL-1:0]   start_span,
   input  logic              ready,
   input  logic              half,
   output logic              busy,
   output logic              done,
   output logic              in_xfer,
   output logic              strobe,
   output logic              part,
   output logic [NL-1:0]     pend,
   output logic [WORD_W-1:0] word,
   output logic [NL-1:0]     ack
);
   localparam int HL = NL / 2;

   seq_state_e        state_q;
   logic              first_q;
   logic              part_q;
   logic [NL-1:0]     pend_q;
   logic [NL-1:0]     rest_q;
   logic [WORD_W-1:0] word_q;

   logic          term;
   logic          low_on;
   logic [NL-1:0] moved;
   logic [NL-1:0] left;

   always_comb begin
      term   = (state_q == SEQ_XFER) && !first_q && ready;
      low_on = |pend_q[HL-1:0];
      moved  = (half && low_on) ? {{HL{1'b0}}, pend_q[HL-1:0]} : pend_q;
      left   = pend_q & ~moved;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         first_q <= 1'b0;
         part_q  <= 1'b0;
         pend_q  <= '0;
         rest_q  <= '0;
         word_q  <= '0;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               if (start) begin
                  state_q <= SEQ_XFER;
                  first_q <= 1'b1;
                  part_q  <= 1'b0;
                  pend_q  <= start_span[NL-1:0];
                  rest_q  <= start_span[2*NL-1:NL];
                  word_q  <= start_word;
               end
            end
            SEQ_XFER: begin
               if (first_q) begin
                  first_q <= 1'b0;
               end else if (term) begin
                  if (left != '0) begin
                     pend_q  <= left;
                     first_q <= 1'b1;
                  end else if (!part_q && (rest_q != '0)) begin
                     part_q  <= 1'b1;
                     pend_q  <= rest_q;
                     rest_q  <= '0;
                     word_q  <= word_q + 1'b1;
                     first_q <= 1'b1;
                  end else begin
                     state_q <= SEQ_DONE;
                  end
               end
            end
            SEQ_DONE: state_q <= SEQ_IDLE;
            default:  state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy    = (state_q != SEQ_IDLE);
   assign done    = (state_q == SEQ_DONE);
   assign in_xfer = (state_q == SEQ_XFER);
   assign strobe  = in_xfer && first_q;
   assign part    = part_q;
   assign pend    = pend_q;
   assign word    = word_q;
   assign ack     = term ? moved : '0;

endmodule

// File: rtl/spl_read_gather.sv
module spl_read_gather #(
   parameter int BUS_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic [1:0]         off_in,
   input  logic [1:0]         size_in,
   input  logic [BUS_W/8-1:0] ack,
   input  logic               part,
   input  logic               from_low,
   input  logic [BUS_W-1:0]   rdata,
   output logic [BUS_W-1:0]   rd_data
);
   localparam int NL = BUS_W / 8;
   localparam int HL = NL / 2;

   logic [2*BUS_W-1:0] rbuf_q;
   logic [1:0]         off_q;
   logic [1:0]         size_q;
   logic [2*BUS_W-1:0] shifted;
   logic [BUS_W-1:0]   keep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbuf_q <= '0;
         off_q  <= '0;
         size_q <= '0;
      end else if (clear) begin
         rbuf_q <= '0;
         off_q  <= off_in;
         size_q <= size_in;
      end else begin
         for (int i = 0; i < NL; i++) begin
            if (ack[i]) begin
               rbuf_q[int'(part)*BUS_W + i*8 +: 8] <=
                  rdata[((from_low && (i >= HL)) ? (i - HL) : i)*8 +: 8];
            end
         end
      end
   end

   always_comb begin
      case (size_q)
         2'b00:   keep = {{(BUS_W-8){1'b0}}, 8'hFF};
         2'b01:   keep = {{(BUS_W-16){1'b0}}, 16'hFFFF};
         default: keep = '1;
      endcase
      shifted = rbuf_q >> {off_q, 3'b000};
      rd_data = shifted[BUS_W-1:0] & keep;
   end

endmodule

// File: rtl/spl_misalign_bus.sv
module spl_misalign_bus
   import spl_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int BUS_W   = 32,
   parameter bit HALF_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic                req_io,
   input  logic [1:0]          req_size,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [BUS_W-1:0]    req_wdata,
   output logic                req_busy,
   output logic                req_done,
   output logic [BUS_W-1:0]    req_rdata,
   output logic                bus_strobe,
   output logic                bus_active,
   output logic [ADDR_W-3:0]   bus_word,
   output logic [BUS_W/8-1:0]  bus_be_n,
   output logic                bus_write,
   output logic                bus_mem,
   output logic [BUS_W-1:0]    bus_wdata,
   input  logic [BUS_W-1:0]    bus_rdata,
   input  logic                bus_ready,
   input  logic                bus_half
);
   localparam int NL     = BUS_W / 8;
   localparam int HL     = NL / 2;
   localparam int WORD_W = ADDR_W - 2;

   if (BUS_W != 32) begin : g_bad_bus
      $error("spl_misalign_bus: BUS_W must be 32");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("spl_misalign_bus: ADDR_W must be at least 4");
   end

   logic              half_eff;
   logic              start;
   logic [2*NL-1:0]   span;
   logic [2*BUS_W-1:0] wide;
   logic              part;
   logic [NL-1:0]     pend;
   logic [NL-1:0]     ack;
   logic [WORD_W-1:0] word;
   logic              upper_only;
   logic              write_q;
   logic              mem_q;

   if (HALF_EN) begin : g_half
      assign half_eff = bus_half;
   end else begin : g_full
      assign half_eff = 1'b0;
   end

   assign start = req_valid && !req_busy;

   spl_lane_plan #(.BUS_W(BUS_W)) u_plan (
      .off   (req_addr[1:0]),
      .size  (req_size),
      .wdata (req_wdata),
      .span  (span),
      .wide  (wide)
   );

   spl_cycle_seq #(.WORD_W(WORD_W), .NL(NL)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_word (req_addr[ADDR_W-1:2]),
      .start_span (span),
      .ready      (bus_ready),
      .half       (half_eff),
      .busy       (req_busy),
      .done       (req_done),
      .in_xfer    (bus_active),
      .strobe     (bus_strobe),
      .part       (part),
      .pend       (pend),
      .word       (word),
      .ack        (ack)
   );

   assign upper_only = ~|pend[HL-1:0];

   spl_write_steer #(.BUS_W(BUS_W)) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start),
      .wide_in   (wide),
      .part      (part),
      .mirror    (upper_only),
      .bus_wdata (bus_wdata)
   );

   spl_read_gather #(.BUS_W(BUS_W)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (start),
      .off_in   (req_addr[1:0]),
      .size_in  (req_size),
      .ack      (ack),
      .part     (part),
      .from_low (half_eff && upper_only),
      .rdata    (bus_rdata),
      .rd_data  (req_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         write_q <= 1'b0;
         mem_q   <= 1'b1;
      end else if (start) begin
         write_q <= req_write;
         mem_q   <= !req_io;
      end
   end

   assign bus_word  = word;
   assign bus_be_n  = bus_active ? ~pend : '1;
   assign bus_write = write_q;
   assign bus_mem   = mem_q;

endmodule

// File: rtl/spl_checks.sv
module spl_checks #(
   parameter int ADDR_W  = 32,
   parameter int BUS_W   = 32,
   parameter bit HALF_EN = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_busy,
   input logic               req_done,
   input logic               bus_strobe,
   input logic               bus_active,
   input logic [ADDR_W-3:0]  bus_word,
   input logic [BUS_W/8-1:0] bus_be_n,
   input logic               bus_write,
   input logic               bus_mem,
   input logic               bus_ready,
   input logic               bus_half
);
   // R2: every cycle enables at least one lane
   a_r2_lane_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      bus_active |-> (bus_be_n != '1));

   // R6: strobe lasts one clock and the cycle goes on after it
   a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      bus_strobe |=> (bus_active && !bus_strobe));

   // R6: cycle attributes hold after the strobe clock
   a_r6_attr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_active && !bus_strobe) |-> ($stable(bus_word) && $stable(bus_be_n)
                                       && $stable(bus_write) && $stable(bus_mem)));

   // R7: no ready means the same cycle continues
   a_r7_wait_state: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_active && !bus_strobe && !bus_ready) |=> (bus_active && !bus_strobe));

   // R10: an idle request is taken
   a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_busy) |=> req_busy);

   // R11: done is a single clock and ends the access
   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |=> (!req_done && !req_busy && !bus_active));

   if (HALF_EN) begin : g_half_chk
      // R8: narrow slave on a two-half cycle forces an upper-half follow-up
      a_r8_half_follow: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_active && !bus_strobe && bus_ready && bus_half
          && (bus_be_n[1:0] != 2'b11) && (bus_be_n[3:2] != 2'b11))
         |=> (bus_strobe && (bus_be_n == {$past(bus_be_n[3:2]), 2'b11})
              && (bus_word == $past(bus_word))));
   end

endmodule

bind spl_misalign_bus spl_checks #(
   .ADDR_W  (ADDR_W),
   .BUS_W   (BUS_W),
   .HALF_EN (HALF_EN)
) u_spl_checks (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_busy   (req_busy),
   .req_done   (req_done),
   .bus_strobe (bus_strobe),
   .bus_active (bus_active),
   .bus_word   (bus_word),
   .bus_be_n   (bus_be_n),
   .bus_write  (bus_write),
   .bus_mem    (bus_mem),
   .bus_ready  (bus_ready),
   .bus_half   (bus_half)
);

// File: tb/test_spl_misalign_bus.sv
module test_spl_misalign_bus;
   localparam int AW    = 10;
   localparam int BW    = 32;
   localparam int MEMSZ = 1 << AW;
   localparam int WORDS = MEMSZ / 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0;
   logic [1:0] req_size = 2'b00;
   logic [AW-1:0] req_addr = '0;
   logic [BW-1:0] req_wdata = '0;
   logic [BW-1:0] bus_rdata = '0;
   logic bus_ready = 1'b0, bus_half = 1'b0;
   logic req_busy, req_done, bus_strobe, bus_active, bus_write, bus_mem;
   logic [BW-1:0] req_rdata, bus_wdata;
   logic [AW-3:0] bus_word;
   logic [3:0] bus_be_n;

   spl_misalign_bus #(.ADDR_W(AW), .BUS_W(BW), .HALF_EN(1'b1)) i_spl_misalign_bus (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_io(req_io), .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_busy(req_busy), .req_done(req_done), .req_rdata(req_rdata),
      .bus_strobe(bus_strobe), .bus_active(bus_active), .bus_word(bus_word),
      .bus_be_n(bus_be_n), .bus_write(bus_write), .bus_mem(bus_mem),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
      .bus_half(bus_half)
   );

   always #5 clk = ~clk;

   int n_tests = 0;
   int n_fail  = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   logic [7:0] dmem    [MEMSZ];
   logic [7:0] ref_mem [MEMSZ];
   int exp_q[$];
   logic [31:0] exp_rd;
   bit cur_wr, cur_io, cur_half;
   bit in_flight = 0, done_flag = 0, hold_chk = 0;
   bit prev_end = 0, prev_active = 0;
   int waits = 0;
   logic [AW-3:0] c_word = '0;
   logic [3:0] c_be = 4'hF;

   // Bus slave model and per-clock protocol comparison
   always @(negedge clk) begin : mon
      bit end_now;
      int e;
      int idx;
      logic [31:0] rd;
      end_now = 0;
      if (!rst_n) begin
         bus_ready = 0;
         prev_end = 0;
         prev_active = 0;
      end else begin
         if (in_flight) begin
            chk(req_done == (prev_end && exp_q.size() == 0), "R11 done timing",
                32'(req_done), 32'(prev_end && exp_q.size() == 0));
            if (req_done) begin
               if (!cur_wr) chk(req_rdata == exp_rd, cur_half ? "R9 load data" : "R5 load data",
                                req_rdata, exp_rd);
               hold_chk = 1;
            end else if (hold_chk) begin
               if (!cur_wr) chk(req_rdata == exp_rd, "R11 load data held", req_rdata, exp_rd);
               chk(!req_busy, "R10 busy released", 32'(req_busy), 0);
               hold_chk = 0;
               in_flight = 0;
               done_flag = 1;
            end
         end
         if (bus_active) begin
            chk(bus_strobe == (prev_end || !prev_active), "R6 strobe placement",
                32'(bus_strobe), 32'(prev_end || !prev_active));
            if (bus_strobe) begin
               if (exp_q.size() == 0) begin
                  chk(0, cur_half ? "R8 extra cycle" : "R3 extra cycle",
                      {22'd0, bus_word, bus_be_n}, 0);
               end else begin
                  e = exp_q.pop_front();
                  chk(bus_word == (AW-2)'(e >> 4) && bus_be_n == 4'(~e),
                      cur_half ? "R8 cycle word/enables" : "R2 R3 cycle word/enables",
                      {20'd0, bus_word, bus_be_n}, {20'd0, (AW-2)'(e >> 4), 4'(~e)});
               end
               chk(bus_write == cur_wr && bus_mem == !cur_io, "R6 write/memory",
                   {30'd0, bus_write, bus_mem}, {30'd0, cur_wr, !cur_io});
               c_word = bus_word;
               c_be = bus_be_n;
               waits = $urandom_range(0, 3);
               bus_ready = 1'($urandom_range(0, 1));  // R7: ignored in strobe clock
               bus_rdata = $urandom;
            end else begin
               chk(bus_word == c_word && bus_be_n == c_be && bus_write == cur_wr
                   && bus_mem == !cur_io, "R6 attributes stable",
                   {20'd0, bus_word, bus_be_n}, {20'd0, c_word, c_be});
               if (waits == 0) begin
                  rd = $urandom;
                  for (int i = 0; i < 4; i++) begin
                     idx = int'(c_word) * 4 + i;
                     if (c_be[i]) continue;
                     if (cur_half && c_be[1:0] == 2'b11) begin
                        rd[(i-2)*8 +: 8] = dmem[idx];
                        if (cur_wr) dmem[idx] = bus_wdata[(i-2)*8 +: 8];
                     end else if (cur_half && i >= 2) begin
                        // narrow slave only moves the lower lanes here
                     end else begin
                        rd[i*8 +: 8] = dmem[idx];
                        if (cur_wr) dmem[idx] = bus_wdata[i*8 +: 8];
                     end
                  end
                  bus_rdata = rd;
                  bus_ready = 1;
                  end_now = 1;
               end else begin
                  waits--;
                  bus_ready = 0;
                  bus_rdata = $urandom;
               end
            end
         end else begin
            bus_ready = 1'($urandom_range(0, 1));  // R7: ignored while idle
            bus_rdata = $urandom;
         end
         prev_active = bus_active;
         prev_end = end_now;
      end
   end

   task automatic do_req(input bit wr, input bit io, input logic [1:0] size, input int addr,
                         input logic [31:0] wd, input bit half, input bit poke);
      int n, off, m, pm, w, idx;
      while (req_busy || in_flight) @(negedge clk);
      n = (size == 2'b00) ? 1 : (size == 2'b01) ? 2 : 4;
      off = addr & 3;
      m = ((1 << n) - 1) << off;
      exp_q.delete();
      for (int p = 0; p < 2; p++) begin
         pm = (m >> (4 * p)) & 15;
         if (pm == 0) continue;
         w = ((addr >> 2) + p) % WORDS;
         if (half && (pm & 3) != 0 && (pm & 12) != 0) begin
            exp_q.push_back(w * 16 + pm);
            exp_q.push_back(w * 16 + (pm & 12));
         end else begin
            exp_q.push_back(w * 16 + pm);
         end
      end
      exp_rd = 0;
      for (int k = 0; k < n; k++) begin
         idx = (addr + k) % MEMSZ;
         exp_rd[k*8 +: 8] = ref_mem[idx];
         if (wr) ref_mem[idx] = wd[k*8 +: 8];
      end
      cur_wr = wr; cur_io = io; cur_half = half;
      bus_half = half;
      in_flight = 1;
      req_valid = 1; req_write = wr; req_io = io; req_size = size;
      req_addr = AW'(addr); req_wdata = wd;
      @(negedge clk);
      req_valid = 0;
      chk(req_busy, "R10 busy after accept", 32'(req_busy), 1);
      if (poke) begin
         // R10: a second request while busy must be dropped
         req_valid = 1; req_addr = AW'(addr + 40); req_write = !wr; req_size = 2'b10;
         @(negedge clk);
         req_valid = 0;
      end
      while (!done_flag) @(negedge clk);
      done_flag = 0;
      for (int j = -2; j < n + 2; j++) begin
         idx = (addr + j + MEMSZ) % MEMSZ;
         chk(dmem[idx] == ref_mem[idx], half ? "R9 store lanes" : "R4 store lanes",
             32'(dmem[idx]), 32'(ref_mem[idx]));
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < MEMSZ; i++) begin
         dmem[i] = 8'(i * 37 + 5);
         ref_mem[i] = 8'(i * 37 + 5);
      end
      repeat (3) @(negedge clk);
      chk(!bus_active && !bus_strobe && !req_busy && !req_done && bus_be_n == 4'hF,
          "R1 reset outputs", {27'd0, bus_active, bus_strobe, req_busy, req_done, 1'b0}, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      chk(!bus_active && !bus_strobe && !req_busy && !req_done && bus_be_n == 4'hF,
          "R1 idle after reset", {27'd0, bus_active, bus_strobe, req_busy, req_done, 1'b0}, 0);

      // Directed sweep: every length, offset, direction, width
      for (int h = 0; h < 2; h++)
         for (int s = 0; s < 3; s++)
            for (int o = 0; o < 4; o++) begin
               do_req(1'b1, 1'b0, 2'(s), 256 + o, 32'hA1B2C3D4 + 32'(o * 16 + s), h[0], 1'b0);
               do_req(1'b0, 1'b1, 2'(s), 256 + o, 32'h0, h[0], 1'b0);
            end
      // Length code 3 behaves as four bytes (R2)
      do_req(1'b0, 1'b0, 2'b11, 513, 32'h0, 1'b0, 1'b0);
      // Wrap past the top word (R3)
      do_req(1'b1, 1'b0, 2'b10, MEMSZ - 2, 32'h11223344, 1'b0, 1'b0);
      do_req(1'b0, 1'b0, 2'b10, MEMSZ - 2, 32'h0, 1'b1, 1'b0);
      do_req(1'b1, 1'b0, 2'b01, MEMSZ - 1, 32'h00005566, 1'b1, 1'b0);
      do_req(1'b0, 1'b0, 2'b01, MEMSZ - 1, 32'h0, 1'b0, 1'b0);
      // Request while busy is ignored (R10)
      do_req(1'b1, 1'b0, 2'b10, 301, 32'hCAFEF00D, 1'b0, 1'b1);
      do_req(1'b0, 1'b0, 2'b10, 341, 32'h0, 1'b1, 1'b1);
      do_req(1'b0, 1'b0, 2'b10, 301, 32'h0, 1'b0, 1'b0);
      // Random mix
      for (int r = 0; r < 250; r++)
         do_req(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                $urandom_range(0, MEMSZ - 1), $urandom, 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)));
      repeat (3) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule